// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block sits between a local bus master and a PCI host bridge core. It turns each local bus address into a PCI bus address and a cycle kind: memory, I/O or configuration. The translation is set by a small bank of programmable apertures. Each aperture has a placement register and a translation register. The placement register gives the local base, the size, the enable and the prefetchable flag. The translation register gives the PCI-side upper address, the cycle kind and how the two lowest address bits are driven.

Apertures may overlap. The hit from the lowest-numbered aperture is always the one used. Software relies on this to enlarge aperture 0 over aperture 1 while it repoints aperture 1 at configuration space, then shrinks aperture 0 again. Configuration cycles use a split device-select scheme. Low slot select bits travel inside the local address. The top select byte comes from the translation register.

The aperture registers are guarded by a lock. The lock is set out of reset and is cleared only by a fixed 16-bit key written to the system register. Results are registered and appear one cycle after the address is presented.

Top module: `pci_window_xlat`

## Requirements
- R1: When more than one enabled aperture contains the address, the lowest-numbered one supplies the whole result (address, kind, prefetch flag), and the others are ignored.
- R2: Aperture i contains an address when its enable bit (placement bit 0) is set and the address bits above the aperture size match placement bits 31:20 at the same positions. The size is 1 MB shifted left by placement bits 7:4 (so 4 is 16 MB, 8 is 256 MB and 9 is 512 MB), with codes above 11 treated as 11. Placement bits below the size are ignored.
- R3: The translated address takes the bits above the aperture size from translation bits 31:20 and passes all lower bits through from the local address.
- R4: An address presented with in_valid that hits no enabled aperture gives out_miss=1, out_valid=0, out_addr=0, out_type=0 and out_pref=0 one cycle later. out_valid and out_miss are never high together.
- R5: out_type encodes memory as 2'b00, I/O as 2'b01 and configuration as 2'b10. Aperture 2 always gives I/O. Apertures 0 and 1 give configuration when translation bits 3:1 equal 3'b101, and memory otherwise.
- R6: When translation bit 0 is 0, out_addr[1:0] is forced to 00. When it is 1, those bits pass through from the local address, which allows the 01 marker of a type 1 configuration address.
- R7: For a configuration result, out_addr[31:24] is replaced by translation bits 15:8, the high device-select bits of a type 0 cycle. Bits below 24 follow R3 and R6.
- R8: out_pref equals placement bit 1 of the aperture that won.
- R9: Register addresses are: 0 for the system register, 1 to 3 for placement 0 to 2, and 4 to 6 for translation 0 to 2. The lock is set by reset. A system write of 16'hA05F in bits 15:0 clears the lock. Any other system write with bit 15 set sets the lock. While the lock is set, aperture register writes are ignored.
- R10: A result appears exactly one clock after in_valid. A register write takes effect for an address presented in the cycle after the write, and not for one presented in the same cycle.
- R11: After reset, all outputs are 0, every aperture register is 0 (so all apertures are disabled), and the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (R9) |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Local address valid |
| in_addr | input | 32 | Local bus address |
| out_valid | output | 1 | Translated PCI cycle valid |
| out_miss | output | 1 | Address hit no enabled aperture |
| out_addr | output | 32 | Translated PCI address |
| out_type | output | 2 | Cycle kind (R5) |
| out_pref | output | 1 | Prefetchable flag of the winning aperture |

## Verification
The hardest situation to reach from the ports is a true overlap in which a higher aperture matches but is hidden, because it only shows when the winner is later disabled or shrunk. The stimulus programs two apertures over the same range with different translations and prefetch flags, translates an address, and then disables aperture 0 so that the same address exposes aperture 1. The configuration remap sequence (enlarge, repoint, translate, restore) is run under the lock protocol, including a write that lands in the same cycle as a translation. A long randomized phase then mixes overlapping placements, key and lock writes, and addresses, and a behavioural model checks every cycle.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_W     = 20;               // 1 MB alignment
  localparam int HI_W       = ADDR_W - GRAN_W;  // translated upper field
  localparam int SZ_W       = 4;
  localparam int SZ_LSB     = 4;
  localparam int MAX_SZ     = HI_W - 1;
  localparam int SEL_LSB    = 24;               // cfg high select field in address
  localparam int SEL_W      = ADDR_W - SEL_LSB;
  localparam int SEL_MAPLSB = 8;                // cfg high select field in map
  localparam int KIND_LSB   = 1;
  localparam logic [2:0]  KIND_CFG   = 3'b101;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam int LOCK_BIT   = 15;

  typedef enum logic [1:0] {
    CYC_MEM = 2'b00,
    CYC_IO  = 2'b01,
    CYC_CFG = 2'b10
  } cyc_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    cyc_t              kind;
    logic              pref;
  } xlat_t;
endpackage

// File: rtl/pxl_rst_sync.sv
module pxl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pxl_regfile.sv
module pxl_regfile import pxl_pkg::*; #(
  parameter int NUM_WIN = 3,
  parameter int CFG_AW  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] base_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] map_o
);
  logic lock_q, lock_d, lock_en;
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q, map_q;
  logic [NUM_WIN-1:0] base_we, map_we;
  logic sys_sel;

  assign sys_sel = (cfg_addr == '0);

  // lock next state
  always_comb begin
    lock_en = cfg_we && sys_sel;
    if (cfg_wdata[15:0] == UNLOCK_KEY) lock_d = 1'b0;
    else                               lock_d = lock_q | cfg_wdata[LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b1;
    else if (lock_en) lock_q <= lock_d;
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win_regs
    assign base_we[i] = cfg_we && !lock_q && (cfg_addr == CFG_AW'(1 + i));
    assign map_we[i]  = cfg_we && !lock_q && (cfg_addr == CFG_AW'(1 + NUM_WIN + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          base_q[i] <= '0;
      else if (base_we[i]) base_q[i] <= cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         map_q[i] <= '0;
      else if (map_we[i]) map_q[i] <= cfg_wdata;
    end
  end

  assign base_o = base_q;
  assign map_o  = map_q;

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && cfg_we && !sys_sel) |=> ($stable(base_q) && $stable(map_q))); // R9
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sys_sel && cfg_wdata[15:0] == UNLOCK_KEY) |=> !lock_q); // R9
endmodule

// File: rtl/pxl_window.sv
module pxl_window import pxl_pkg::*; #(
  parameter bit IS_IO = 1'b0
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] map_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output xlat_t             res_o
);
  logic [SZ_W-1:0] sz_raw, sz;
  logic [HI_W-1:0] keep;   // 1 = bit lies above the aperture size
  logic [HI_W-1:0] xhi;
  logic            is_cfg;
  logic [ADDR_W-1:0] xa;
  logic unused_bits;

  assign sz_raw = base_i[SZ_LSB +: SZ_W];
  assign sz     = (int'(sz_raw) > MAX_SZ) ? SZ_W'(MAX_SZ) : sz_raw;

  for (genvar k = 0; k < HI_W; k++) begin : g_keep
    assign keep[k] = (k >= int'(sz));
  end

  assign hit_o  = base_i[0] &&
                  (((addr_i[ADDR_W-1:GRAN_W] ^ base_i[ADDR_W-1:GRAN_W]) & keep) == '0);
  assign xhi    = (map_i[ADDR_W-1:GRAN_W] & keep) | (addr_i[ADDR_W-1:GRAN_W] & ~keep);
  assign is_cfg = !IS_IO && (map_i[KIND_LSB +: 3] == KIND_CFG);

  always_comb begin
    xa = {xhi, addr_i[GRAN_W-1:0]};
    if (is_cfg) xa[ADDR_W-1:SEL_LSB] = map_i[SEL_MAPLSB +: SEL_W];
    if (!map_i[0]) xa[1:0] = 2'b00;
  end

  assign res_o.addr = xa;
  assign res_o.kind = IS_IO ? CYC_IO : (is_cfg ? CYC_CFG : CYC_MEM);
  assign res_o.pref = base_i[1];

  assign unused_bits = ^{base_i[GRAN_W-1:SZ_LSB+SZ_W], base_i[3:2],
                         map_i[GRAN_W-1:SEL_MAPLSB+SEL_W], map_i[SEL_MAPLSB-1:KIND_LSB+3]};
endmodule

// File: rtl/pxl_select.sv
module pxl_select import pxl_pkg::*; #(
  parameter int NUM_WIN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NUM_WIN-1:0]   hits_i,
  input  xlat_t [NUM_WIN-1:0]  res_i,
  output logic                 valid_o,
  output logic                 miss_o,
  output xlat_t                x_o
);
  logic  any_hit, valid_d, miss_d, load_en;
  logic  valid_q, miss_q;
  xlat_t pick, x_d, x_q;

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    pick = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits_i[i]) pick = res_i[i];
    end
  end

  always_comb begin
    any_hit = |hits_i;
    valid_d = in_valid && any_hit;
    miss_d  = in_valid && !any_hit;
    x_d     = valid_d ? pick : '0;
    load_en = in_valid || valid_q || miss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
      x_q     <= '0;
    end else if (load_en) begin
      valid_q <= valid_d;
      miss_q  <= miss_d;
      x_q     <= x_d;
    end
  end

  assign valid_o = valid_q;
  assign miss_o  = miss_q;
  assign x_o     = x_q;

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && miss_q)); // R4
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (valid_q || miss_q)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!valid_q && !miss_q)); // R10
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hits_i[0]) |=> (valid_q && x_q == $past(res_i[0]))); // R1
endmodule

// File: rtl/pci_window_xlat.sv
module pci_window_xlat import pxl_pkg::*; #(
  parameter  int NUM_WIN = 3,
  parameter  int IO_WIN  = 2,
  localparam int CFG_AW  = $clog2(2 * NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              out_valid,
  output logic              out_miss,
  output logic [31:0]       out_addr,
  output logic [1:0]        out_type,
  output logic              out_pref
);
  logic rst_int_n;
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_w, map_w;
  logic [NUM_WIN-1:0] hits;
  xlat_t [NUM_WIN-1:0] res;
  xlat_t x_out;

  pxl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pxl_regfile #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_w),
    .map_o     (map_w)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    pxl_window #(.IS_IO(i == IO_WIN)) u_win (
      .base_i (base_w[i]),
      .map_i  (map_w[i]),
      .addr_i (in_addr),
      .hit_o  (hits[i]),
      .res_o  (res[i])
    );
  end

  pxl_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .hits_i   (hits),
    .res_i    (res),
    .valid_o  (out_valid),
    .miss_o   (out_miss),
    .x_o      (x_out)
  );

  assign out_addr = x_out.addr;
  assign out_type = x_out.kind;
  assign out_pref = x_out.pref;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_miss |-> (out_addr == '0 && out_type == 2'b00 && !out_pref)); // R4
  AST_IO_WIN_KIND: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && hits == NUM_WIN'(1 << IO_WIN)) |=> (out_type == CYC_IO)); // R5
  AST_NO_MISS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && |hits) |=> out_valid); // R2
endmodule

// File: tb/pci_window_xlat_tb.sv
module pci_window_xlat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid, out_miss, out_pref;
  logic [31:0] out_addr;
  logic [1:0]  out_type;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_en = 0;
  string cur_req = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_window_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_miss(out_miss), .out_addr(out_addr),
    .out_type(out_type), .out_pref(out_pref)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_base [NW];
  logic [31:0] m_map  [NW];
  bit          m_lock;
  bit          e_valid, e_miss, e_pref;
  logic [31:0] e_addr;
  logic [1:0]  e_type;

  function automatic void ref_x(input logic [31:0] a, output bit v,
                                output logic [31:0] xa, output logic [1:0] t,
                                output bit p);
    v = 0; xa = '0; t = 2'b00; p = 0;
    for (int i = NW - 1; i >= 0; i--) begin
      int code;
      int sh;
      longint unsigned la, lb, lm;
      code = int'(m_base[i][7:4]);
      if (code > 11) code = 11;
      sh = 20 + code;
      la = 64'(a); lb = 64'(m_base[i]); lm = 64'(m_map[i]);
      if (m_base[i][0] && ((la >> sh) == (lb >> sh))) begin
        v  = 1;
        xa = 32'(((lm >> sh) << sh) | (la & ((64'd1 << sh) - 1)));
        if (i == 2) t = 2'b01;
        else if (m_map[i][3:1] == 3'b101) begin
          t = 2'b10;
          xa[31:24] = m_map[i][15:8];
        end else t = 2'b00;
        if (!m_map[i][0]) xa[1:0] = 2'b00;
        p = m_base[i][1];
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin m_base[i] = '0; m_map[i] = '0; end
      m_lock = 1; e_valid = 0; e_miss = 0; e_addr = '0; e_type = '0; e_pref = 0;
    end else begin
      bit v, p;
      logic [31:0] xa;
      logic [1:0] t;
      ref_x(in_addr, v, xa, t, p);
      e_valid = in_valid && v;
      e_miss  = in_valid && !v;
      e_addr  = e_valid ? xa : '0;
      e_type  = e_valid ? t : '0;
      e_pref  = e_valid ? p : 1'b0;
      if (cfg_we) begin
        if (cfg_addr == 0) begin
          if (cfg_wdata[15:0] == 16'hA05F) m_lock = 0;
          else if (cfg_wdata[15]) m_lock = 1;
        end else if (!m_lock) begin
          if (cfg_addr <= 3) m_base[cfg_addr - 1] = cfg_wdata;
          else if (cfg_addr <= 6) m_map[cfg_addr - 4] = cfg_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_req, "model valid", 32'(out_valid), 32'(e_valid));
      chk(cur_req, "model miss",  32'(out_miss),  32'(e_miss));
      chk(cur_req, "model addr",  out_addr,       e_addr);
      chk(cur_req, "model type",  32'(out_type),  32'(e_type));
      chk(cur_req, "model pref",  32'(out_pref),  32'(e_pref));
    end
  end

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xl(input string tag, input logic [31:0] a, input bit v,
                    input logic [31:0] ea, input logic [1:0] et, input bit ep);
    in_valid = 1; in_addr = a;
    @(negedge clk);
    in_valid = 0;
    chk(tag, "valid", 32'(out_valid), 32'(v));
    chk(tag, "miss",  32'(out_miss),  32'(!v));
    chk(tag, "addr",  out_addr, ea);
    chk(tag, "type",  32'(out_type), 32'(et));
    chk(tag, "pref",  32'(out_pref), 32'(ep));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11", "reset valid", 32'(out_valid), 0);
    chk("R11", "reset miss",  32'(out_miss), 0);
    chk("R11", "reset addr",  out_addr, 0);
    cmp_en = 1;
    xl("R11", 32'h4123_4567, 0, 0, 0, 0);

    // R9 locked writes ignored
    cur_req = "R9";
    wr(3'd1, 32'h4000_0081);
    xl("R9", 32'h4123_4567, 0, 0, 0, 0);
    wr(3'd0, 32'h0000_A05F);

    // program three apertures
    cur_req = "R3";
    wr(3'd1, 32'h4000_0081); wr(3'd4, 32'h0000_0007);
    wr(3'd2, 32'h5000_0083); wr(3'd5, 32'h1000_0007);
    wr(3'd3, 32'h6000_0041); wr(3'd6, 32'h0000_0001);
    xl("R3", 32'h4123_4567, 1, 32'h0123_4567, 2'b00, 0);
    xl("R8", 32'h5ABC_DEF3, 1, 32'h1ABC_DEF3, 2'b00, 1);
    xl("R5", 32'h60FF_0002, 1, 32'h00FF_0002, 2'b01, 0);
    xl("R4", 32'h7000_0000, 0, 0, 0, 0);
    xl("R2", 32'h6100_0000, 0, 0, 0, 0);
    cur_req = "R2";
    wr(3'd1, 32'h4FF0_0081);
    xl("R2", 32'h4123_4567, 1, 32'h0123_4567, 2'b00, 0);
    cur_req = "R6";
    wr(3'd4, 32'h0000_0006);
    xl("R6", 32'h4123_4567, 1, 32'h0123_4564, 2'b00, 0);
    wr(3'd4, 32'h0000_0007);

    // R1 overlap
    cur_req = "R1";
    wr(3'd1, 32'h4000_0091);
    xl("R1", 32'h5000_0010, 1, 32'h1000_0010, 2'b00, 0);
    wr(3'd2, 32'h4000_0083);
    xl("R1", 32'h4500_0000, 1, 32'h0500_0000, 2'b00, 0);
    wr(3'd1, 32'h4000_0090);
    xl("R1", 32'h4500_0000, 1, 32'h1500_0000, 2'b00, 1);
    wr(3'd1, 32'h4000_0091);

    // R7 configuration remap
    cur_req = "R7";
    wr(3'd2, 32'h6100_0041); wr(3'd5, 32'h0000_020A);
    xl("R7", 32'h6100_0A13, 1, 32'h0200_0A10, 2'b10, 0);
    wr(3'd5, 32'h0000_000B);
    xl("R6", 32'h6101_0A05, 1, 32'h0001_0A05, 2'b10, 0);

    // R10 write in same cycle as translation
    cur_req = "R10";
    cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = 32'h0000_040A;
    xl("R10", 32'h6100_0A13, 1, 32'h0000_0A13, 2'b10, 0);
    cfg_we = 0;
    xl("R10", 32'h6100_0A13, 1, 32'h0400_0A10, 2'b10, 0);

    // R9 relock, non-key write keeps lock
    cur_req = "R9";
    wr(3'd0, 32'h0000_8000);
    wr(3'd2, 32'h0000_0000);
    xl("R9", 32'h6100_0A13, 1, 32'h0400_0A10, 2'b10, 0);
    wr(3'd0, 32'h0000_1234);
    wr(3'd5, 32'h0000_0000);
    xl("R9", 32'h6100_0A13, 1, 32'h0400_0A10, 2'b10, 0);
    wr(3'd0, 32'h0000_A05F);

    // randomized phase checked by the model every clock
    cur_req = "R1";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      in_valid = r[0];
      in_addr  = {4'h4 + 4'($urandom % 3), 28'($urandom)};
      cfg_we   = (r[3:1] == 3'd0);
      cfg_addr = 3'($urandom % 7);
      if (cfg_addr == 0)
        cfg_wdata = r[5] ? 32'h0000_A05F : (r[6] ? 32'h0000_8000 : 32'($urandom));
      else if (cfg_addr <= 3)
        cfg_wdata = {4'h4 + 4'($urandom % 3), 8'($urandom), 12'h0,
                     4'($urandom % 12), 2'b00, 1'($urandom), r[7] | r[8]};
      else
        cfg_wdata = {16'($urandom), 8'($urandom), 4'h0,
                     (r[9] ? 3'b101 : 3'b011), 1'($urandom)};
      @(negedge clk);
    end
    in_valid = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule